// File: doc/BRIEF.md
# Indirect Codec Register Window

This block lets a host bus reach a bank of 8-bit codec control registers through two 32-bit words. The first word is the command word: the host writes a 7-bit register index, a data byte and, when it wants a write, a request bit. The second word returns the byte of the register that was last addressed, together with a copy of the codec interrupt line. Software writes the command word, polls the request bit until it clears, and for reads waits a fixed number of cycles after changing the index before it samples the data word.

The block holds the register bank itself, with reset values, a read-only status slot at index 0 that shows a live status input, two missing indices, and a fixed write duration during which further commands are refused.

Top module: `codec_reg_window`

## Requirements
- R1: After reset, each register index reads back its default: index 1 and 2 give 0xC3, 3 gives 0x90, 4 gives 0x98, 6 gives 0x90, 7 gives 0xB1, 8 gives 0x11, 9 gives 0x10, 11 gives 0x03, 14 gives 0x40, 16 gives 0xFF, 18 to 21 give 0x06, 31 gives 0x34, 32 gives 0x07, 33 gives 0x44, 34 gives 0x1F, and every other index in 1..35 gives 0x00.
- R2: The command word sits at host byte offset 0x0 and the data word at offset 0x4; any other offset reads zero. In the command word bit 16 is the write request, bits 14:8 the register index and bits 7:0 the data byte; the host reads back the last accepted index and byte in the same positions, and the whole word is zero after reset.
- R3: A command accepted with bit 16 set shows bit 16 high for exactly 4 clock cycles; in the edge that drops it, the byte is stored in the addressed register.
- R4: After a command changes the index, data word bits 7:0 keep their previous value through 5 further clock edges and show the new register's value from the 6th edge on.
- R5: Indices 5 and 28 do not exist: they read as 0x00 and writes to them change no register.
- R6: Index 0 reads the status input byte; writes to index 0 are ignored.
- R7: A command written while bit 16 is high is dropped: the index, byte and register bank stay unchanged.
- R8: Data word bit 8 follows the interrupt input in the same cycle.
- R9: Indices 36 to 127 read as 0x00 and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 3 | Host byte offset; 0 selects the command word, 4 the data word |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, decoded from bus_addr without delay |
| irq_in | input | 1 | Codec interrupt request, mirrored in the data word |
| status_in | input | 8 | Live status byte shown at register index 0 |

## Verification
A command is captured at the edge where the strobe is high, so the command word reflects it half a cycle later; the write request bit is then sampled at each of the following falling edges and must be high for the capture cycle plus three more and low after the fourth edge. The data byte is sampled at the falling edge after each of the six edges that follow an index change, old value through the fifth and new value after the sixth, and every other read waits for that sixth edge. The interrupt bit and offset decode are combinational and are sampled one nanosecond after the inputs change, away from any clock edge.

// File: rtl/codec_reg_window.sv
module codec_reg_window #(
  parameter int NREG      = 36,
  parameter int AW        = 7,
  parameter int WR_CYCLES = 4,
  parameter int RD_LAT    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_en,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        irq_in,
  input  logic [7:0]  status_in
);
  localparam int CW  = $clog2(WR_CYCLES + 1);
  localparam int RCW = $clog2(RD_LAT + 1);

  function automatic logic [7:0] dflt(int i);
    case (i)
      1, 2:           return 8'hC3;
      3, 6:           return 8'h90;
      4:              return 8'h98;
      7:              return 8'hB1;
      8:              return 8'h11;
      9:              return 8'h10;
      11:             return 8'h03;
      14:             return 8'h40;
      16:             return 8'hFF;
      18, 19, 20, 21: return 8'h06;
      31:             return 8'h34;
      32:             return 8'h07;
      33:             return 8'h44;
      34:             return 8'h1F;
      default:        return 8'h00;
    endcase
  endfunction

  function automatic logic exists(int i);
    return (i < NREG) && (i != 5) && (i != 28);
  endfunction

  logic [7:0]    bank [NREG];
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          busy_q;
  logic [CW-1:0] wr_cnt;
  logic [RCW-1:0] rd_cnt;
  logic [7:0]    rd_byte;
  logic [7:0]    rd_val;

  wire cmd_hit = bus_wr_en && (bus_addr == 3'd0);
  wire accept  = cmd_hit && !busy_q;
  wire commit  = busy_q && (wr_cnt == CW'(WR_CYCLES - 1));
  wire unused_wdata = ^{bus_wdata[31:17], bus_wdata[15]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      busy_q <= 1'b0;
      wr_cnt <= '0;
    end else if (accept) begin
      addr_q <= bus_wdata[8 +: AW];
      data_q <= bus_wdata[7:0];
      busy_q <= bus_wdata[16];
      wr_cnt <= '0;
    end else if (busy_q) begin
      if (commit) busy_q <= 1'b0;
      wr_cnt <= wr_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= dflt(i);
    end else begin
      for (int i = 1; i < NREG; i++)
        if (commit && exists(i) && addr_q == AW'(i)) bank[i] <= data_q;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (addr_q == '0) rd_val = status_in;
    for (int i = 1; i < NREG; i++)
      if (exists(i) && addr_q == AW'(i)) rd_val = bank[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt  <= '0;
      rd_byte <= '0;
    end else begin
      if (accept) rd_cnt <= RCW'(RD_LAT);
      else if (rd_cnt != '0) rd_cnt <= rd_cnt - RCW'(1);
      if (!accept && rd_cnt < RCW'(2)) rd_byte <= rd_val;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {15'd0, busy_q, 1'b0, addr_q, data_q};
      3'd4:    bus_rdata = {23'd0, irq_in, rd_byte};
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/codec_reg_window_chk.sv
module codec_reg_window_chk #(
  parameter int AW        = 7,
  parameter int RCW       = 3,
  parameter int WR_CYCLES = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr_en,
  input logic [2:0]     bus_addr,
  input logic           irq_bit,
  input logic           irq_in,
  input logic           busy,
  input logic [AW-1:0]  addr,
  input logic [RCW-1:0] rd_cnt,
  input logic [7:0]     rd_byte
);
  localparam int HW = $clog2(WR_CYCLES + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= '0;
    else hi_cnt <= busy ? hi_cnt + HW'(1) : '0;
  end

  p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> hi_cnt < HW'(WR_CYCLES));

  p_busy_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> hi_cnt == HW'(WR_CYCLES));

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr_en && bus_addr == 3'd0) |=> $stable(addr));

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt > RCW'(1)) |=> $stable(rd_byte));

  p_hole_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(5) && rd_cnt == '0 && $past(addr) == AW'(5)) |-> rd_byte == 8'h00);

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd4) |-> irq_bit == irq_in);
endmodule

bind codec_reg_window codec_reg_window_chk #(
  .AW(AW), .RCW(RCW), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .irq_bit(bus_rdata[8]), .irq_in(irq_in), .busy(busy_q), .addr(addr_q),
  .rd_cnt(rd_cnt), .rd_byte(rd_byte)
);

// File: tb/codec_reg_window_test.sv
`timescale 1ns/1ps
module codec_reg_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_in = 1'b0;
  logic [7:0]  status_in = 8'h00;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] model [36];

  codec_reg_window uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .status_in(status_in)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] reset_val(int i);
    case (i)
      1, 2: return 8'hC3;
      3, 6: return 8'h90;
      4: return 8'h98;
      7: return 8'hB1;
      8: return 8'h11;
      9: return 8'h10;
      11: return 8'h03;
      14: return 8'h40;
      16: return 8'hFF;
      18, 19, 20, 21: return 8'h06;
      31: return 8'h34;
      32: return 8'h07;
      33: return 8'h44;
      34: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit writable(int a);
    return a >= 1 && a <= 35 && a != 5 && a != 28;
  endfunction

  function automatic logic [7:0] expect_read(int a);
    if (a == 0) return status_in;
    if (!writable(a)) return 8'h00;
    return model[a];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(int a, bit wr, logic [7:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1;
    bus_addr  = 3'd0;
    bus_wdata = {15'd0, wr, 1'b0, 7'(a), d};
    @(negedge clk);
    bus_wr_en = 1'b0;
    bus_wdata = 32'd0;
  endtask

  task automatic wait_idle();
    bus_addr = 3'd0;
    #1;
    while (bus_rdata[16]) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic write_reg(int a, logic [7:0] d);
    issue(a, 1'b1, d);
    wait_idle();
    if (writable(a)) model[a] = d;
  endtask

  task automatic read_reg(int a, output logic [7:0] v);
    issue(a, 1'b0, 8'h00);
    repeat (6) @(negedge clk);
    bus_addr = 3'd4;
    #1;
    v = bus_rdata[7:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 36; i++) model[i] = reset_val(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;

    bus_addr = 3'd0; #1;
    check(bus_rdata == 32'd0, "R2 reset command word", bus_rdata, 32'd0);
    bus_addr = 3'd4; #1;
    check(bus_rdata == 32'd0, "R2 reset data word", bus_rdata, 32'd0);
    bus_addr = 3'd2; #1;
    check(bus_rdata == 32'd0, "R2 unmapped offset", bus_rdata, 32'd0);

    status_in = 8'h6B;
    for (int i = 0; i < 36; i++) begin
      read_reg(i, v);
      check(v == expect_read(i), "R1 reset default", v, expect_read(i));
    end

    issue(33, 1'b0, 8'h77);
    bus_addr = 3'd0; #1;
    check(bus_rdata == 32'h0000_2177, "R2 command readback", bus_rdata, 32'h0000_2177);

    issue(20, 1'b1, 8'h3C);
    bus_addr = 3'd0; #1;
    check(bus_rdata[16] == 1'b1, "R3 busy at capture", bus_rdata[16], 1);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); #1;
      check(bus_rdata[16] == 1'b1, "R3 busy held", bus_rdata[16], 1);
    end
    @(negedge clk); #1;
    check(bus_rdata[16] == 1'b0, "R3 busy cleared", bus_rdata[16], 0);
    model[20] = 8'h3C;
    read_reg(20, v);
    check(v == 8'h3C, "R3 write stored", v, 8'h3C);

    write_reg(7, 8'hA5);
    write_reg(8, 8'h5C);
    read_reg(7, v);
    issue(8, 1'b0, 8'h00);
    bus_addr = 3'd4; #1;
    check(bus_rdata[7:0] == 8'hA5, "R4 old value at capture", bus_rdata[7:0], 8'hA5);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk); #1;
      check(bus_rdata[7:0] == 8'hA5, "R4 old value held", bus_rdata[7:0], 8'hA5);
    end
    @(negedge clk); #1;
    check(bus_rdata[7:0] == 8'h5C, "R4 new value after latency", bus_rdata[7:0], 8'h5C);

    write_reg(5, 8'h5A);
    write_reg(28, 8'h5A);
    read_reg(5, v);
    check(v == 8'h00, "R5 hole 5 reads zero", v, 0);
    read_reg(28, v);
    check(v == 8'h00, "R5 hole 28 reads zero", v, 0);
    read_reg(4, v);
    check(v == model[4], "R5 neighbour 4 intact", v, model[4]);
    read_reg(6, v);
    check(v == model[6], "R5 neighbour 6 intact", v, model[6]);
    read_reg(27, v);
    check(v == model[27], "R5 neighbour 27 intact", v, model[27]);

    status_in = 8'h2E;
    write_reg(0, 8'hFF);
    read_reg(0, v);
    check(v == 8'h2E, "R6 status index read-only", v, 8'h2E);

    issue(10, 1'b1, 8'h55);
    issue(11, 1'b1, 8'hAA);
    bus_addr = 3'd0; #1;
    check(bus_rdata[14:0] == 15'h0A55, "R7 dropped command keeps index and byte",
          bus_rdata[14:0], 15'h0A55);
    wait_idle();
    model[10] = 8'h55;
    read_reg(11, v);
    check(v == model[11], "R7 dropped write leaves bank", v, model[11]);
    read_reg(10, v);
    check(v == 8'h55, "R7 first write lands", v, 8'h55);

    bus_addr = 3'd4; irq_in = 1'b1; #1;
    check(bus_rdata[8] == 1'b1, "R8 irq high", bus_rdata[8], 1);
    irq_in = 1'b0; #1;
    check(bus_rdata[8] == 1'b0, "R8 irq low", bus_rdata[8], 0);

    write_reg(36, 8'h99);
    write_reg(127, 8'h99);
    read_reg(36, v);
    check(v == 8'h00, "R9 index 36 reads zero", v, 0);
    read_reg(127, v);
    check(v == 8'h00, "R9 index 127 reads zero", v, 0);

    for (int n = 0; n < 250; n++) begin
      int sel;
      int a;
      logic [7:0] d;
      sel = int'($urandom % 8);
      if (sel == 0) a = ($urandom % 2) ? 5 : 28;
      else if (sel == 1) a = 36 + int'($urandom % 92);
      else a = int'($urandom % 36);
      d = 8'($urandom);
      status_in = 8'($urandom);
      if ($urandom % 2) write_reg(a, d);
      read_reg(a, v);
      if (a > 35) check(v == 8'h00, "R9 random out of range", v, 0);
      else if (a == 5 || a == 28) check(v == 8'h00, "R5 random hole", v, 0);
      else if (a == 0) check(v == status_in, "R6 random status", v, status_in);
      else check(v == model[a], "R3 random write/read", v, model[a]);
      irq_in = 1'($urandom);
      #1;
      check(bus_rdata[8] == irq_in, "R8 random irq", bus_rdata[8], irq_in);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule